// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Walker

This block steps through a circular table of buffer descriptors kept in a small local RAM, on behalf of one serial receive channel. Each descriptor is four 16-bit words: a status/control word, a length word, and the high and low halves of a 32-bit buffer pointer. The walker checks the descriptor it is pointing at, and when the host has marked it empty it gives the buffer to the data path. Incoming bytes are then written through a byte-write port at pointer plus count. When the buffer closes, the walker writes back the length and status and moves to the next descriptor.

A buffer closes when it reaches the programmed maximum length, when the data path flags the last byte of a frame, or when the host issues a close command so that it can read a partly filled buffer. If the descriptor is not empty, the walker flags a busy error once and waits on that descriptor. A wrap bit marks the last entry of the table, and a continuous bit lets a descriptor be reused without going back to the host. Two configuration registers, the table base and the maximum buffer length, can be read at any time but accept writes only while the channel is disabled.

Top module: `bd_ring_walker`

## Requirements
- R1: After reset, buf_own, buf_we, irq and busy_err are 0, the base register reads 0 (cfg_sel=0) and the maximum length register reads DEF_MAXLEN (cfg_sel=1).
- R2: A configuration write is ignored while chan_en is 1. A base write whose value has any of bits 2:0 set is rejected (register unchanged). A maximum length write of 0 is rejected. Both registers can be read at any time.
- R3: When chan_en rises, the walker starts at the base byte address. A descriptor at byte address A holds status at halfword A/2, length at A/2+1, pointer[31:16] at A/2+2 and pointer[15:0] at A/2+3. It is taken only if status bit 15 (empty) is set, and buf_own is then asserted. Each accepted byte drives buf_we with buf_addr = pointer + bytes already in the buffer.
- R4: If the current descriptor has bit 15 clear, busy_err and irq pulse for exactly one cycle. The walker stays on that descriptor with buf_own low, and takes it once the host sets bit 15.
- R5: The byte that brings the count to the maximum length closes the buffer. Its length is written to the length word, status bit 15 is cleared, the other status bits are kept, and irq pulses for one cycle.
- R6: A byte with rx_eof set closes the buffer with a length that includes that byte.
- R7: close_cmd closes the current buffer with the bytes received so far. Bytes that follow go into the next descriptor's buffer.
- R8: After a close, the next descriptor is at the table base if status bit 13 (wrap) of the closed descriptor was set, and at the byte address plus 8 otherwise.
- R9: If status bit 9 (continuous) is set, bit 15 stays set at close, so the descriptor can be taken again without host action.
- R10: close_cmd in the same cycle as a byte gives one close, whose length counts that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; a rising edge restarts at the base |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects base register, 1 selects maximum length |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Selected configuration register |
| host_we | input | 1 | Host write strobe into descriptor RAM |
| host_addr | input | AW-1 | Host halfword index into descriptor RAM |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Descriptor RAM word at host_addr |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | The present byte ends a frame |
| close_cmd | input | 1 | Close the current buffer now |
| buf_own | output | 1 | A buffer is held by the data path |
| buf_we | output | 1 | Byte write to buffer memory |
| buf_addr | output | 32 | Buffer memory byte address |
| buf_wdata | output | 8 | Buffer memory write data |
| irq | output | 1 | One-cycle pulse on a close or a busy error |
| busy_err | output | 1 | One-cycle pulse when no empty descriptor is found |

## Verification
Two close causes can land on the same edge: a close command and the byte that would close the buffer on its own. The bench drives close_cmd together with a data byte and then reads back the length word to confirm that a single close took place and that the byte was counted. It also checks that the following descriptor is chosen from the wrap bit. The other overlap is a host write that sets the empty bit while the walker is stalled on that descriptor. In that case the bench expects ownership one cycle after the write lands and no second busy pulse.

// File: rtl/bdw_pkg.sv
package bdw_pkg;
   localparam int STAT_EMPTY_BIT = 15;
   localparam int STAT_WRAP_BIT  = 13;
   localparam int STAT_CONT_BIT  = 9;
   localparam int PTR_W          = 32;
   localparam int WORD_W         = 16;
   localparam int DESC_BYTES     = 8;

   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_CHECK  = 2'd1,
      WK_ACTIVE = 2'd2
   } walk_state_t;
endpackage

// File: rtl/bdw_cfg_regs.sv
module bdw_cfg_regs #(
   parameter int AW           = 7,
   parameter int LEN_W        = 16,
   parameter int DEF_MAXLEN   = 16,
   parameter bit ALIGN_REJECT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [15:0]      cfg_wdata,
   output logic [15:0]      cfg_rdata,
   output logic [AW-1:0]    base_q,
   output logic [LEN_W-1:0] maxlen_q
);
   if (AW < 4 || AW > 16) begin : g_bad_aw
      $error("bdw_cfg_regs: AW must be within 4..16");
   end
   if (LEN_W < 2 || LEN_W > 16) begin : g_bad_len
      $error("bdw_cfg_regs: LEN_W must be within 2..16");
   end
   if (DEF_MAXLEN < 1 || DEF_MAXLEN >= (1 << LEN_W)) begin : g_bad_def
      $error("bdw_cfg_regs: DEF_MAXLEN out of range");
   end

   logic          base_ok;
   logic [AW-1:0] base_in;

   if (ALIGN_REJECT) begin : g_reject
      assign base_ok = (cfg_wdata[2:0] == 3'b000);
      assign base_in = cfg_wdata[AW-1:0];
   end else begin : g_round
      assign base_ok = 1'b1;
      assign base_in = {cfg_wdata[AW-1:3], 3'b000};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         maxlen_q <= LEN_W'(DEF_MAXLEN);
      end else if (cfg_we && !chan_en) begin
         if (!cfg_sel) begin
            if (base_ok) base_q <= base_in;
         end else if (cfg_wdata[LEN_W-1:0] != '0) begin
            maxlen_q <= cfg_wdata[LEN_W-1:0];
         end
      end
   end

   assign cfg_rdata = cfg_sel ? 16'(maxlen_q) : 16'(base_q);

   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      base_q[2:0] == 3'b000) else $error("base misaligned"); // R2
   AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chan_en) |-> $stable(base_q)) else $error("base changed while enabled"); // R2
   AST_MAXLEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      maxlen_q != '0) else $error("max length zero"); // R2
endmodule

// File: rtl/bdw_desc_ram.sv
module bdw_desc_ram #(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic [AW-2:0] rd_idx,
   output logic [15:0]   rd_status,
   output logic [31:0]   rd_ptr,
   input  logic          wb_we,
   input  logic [AW-2:0] wb_idx,
   input  logic [15:0]   wb_status,
   input  logic [15:0]   wb_len,
   input  logic          host_we,
   input  logic [AW-2:0] host_addr,
   input  logic [15:0]   host_wdata,
   output logic [15:0]   host_rdata
);
   localparam int HAW   = AW - 1;
   localparam int WORDS = 1 << HAW;

   logic [WORDS*16-1:0] flat;
   logic [HAW-1:0]      wb_idx_len;
   logic [HAW-1:0]      rd_idx_hi;
   logic [HAW-1:0]      rd_idx_lo;

   assign wb_idx_len = wb_idx + HAW'(1);
   assign rd_idx_hi  = rd_idx + HAW'(2);
   assign rd_idx_lo  = rd_idx + HAW'(3);

   for (genvar g = 0; g < WORDS; g++) begin : g_row
      logic [15:0] word_q;
      always_ff @(posedge clk) begin
         if (wb_we && wb_idx == HAW'(g))
            word_q <= wb_status;
         else if (wb_we && wb_idx_len == HAW'(g))
            word_q <= wb_len;
         else if (host_we && host_addr == HAW'(g))
            word_q <= host_wdata;
      end
      assign flat[g*16 +: 16] = word_q;
   end

   assign rd_status  = flat[rd_idx*16 +: 16];
   assign rd_ptr     = {flat[rd_idx_hi*16 +: 16], flat[rd_idx_lo*16 +: 16]};
   assign host_rdata = flat[host_addr*16 +: 16];
endmodule

// File: rtl/bdw_walker.sv
module bdw_walker
   import bdw_pkg::*;
#(
   parameter int AW    = 7,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic [AW-1:0]    base,
   input  logic [LEN_W-1:0] maxlen,
   input  logic [15:0]      d_status,
   input  logic [31:0]      d_ptr,
   output logic [AW-2:0]    rd_idx,
   output logic             wb_we,
   output logic [AW-2:0]    wb_idx,
   output logic [15:0]      wb_status,
   output logic [15:0]      wb_len,
   input  logic             rx_valid,
   input  logic [7:0]       rx_byte,
   input  logic             rx_eof,
   input  logic             close_cmd,
   output logic             buf_own,
   output logic             buf_we,
   output logic [31:0]      buf_addr,
   output logic [7:0]       buf_wdata,
   output logic             irq,
   output logic             busy_err
);
   walk_state_t      state_q;
   logic [AW-1:0]    cur_q;
   logic [LEN_W-1:0] cnt_q;
   logic [31:0]      ptr_q;
   logic [15:0]      stat_q;
   logic             busy_seen_q;
   logic             irq_q;
   logic             busy_q;

   logic             st_empty;
   logic             byte_in;
   logic             hit_max;
   logic             closing;
   logic             busy_fire;
   logic [LEN_W-1:0] len_final;
   logic [AW-1:0]    next_cur;

   always_comb begin
      st_empty  = d_status[STAT_EMPTY_BIT];
      byte_in   = (state_q == WK_ACTIVE) && chan_en && rx_valid;
      hit_max   = byte_in && ((cnt_q + LEN_W'(1)) == maxlen);
      closing   = (state_q == WK_ACTIVE) && chan_en &&
                  (close_cmd || hit_max || (byte_in && rx_eof));
      busy_fire = (state_q == WK_CHECK) && chan_en && !st_empty && !busy_seen_q;
      len_final = cnt_q + LEN_W'(byte_in);
      next_cur  = stat_q[STAT_WRAP_BIT] ? base : cur_q + AW'(DESC_BYTES);
      wb_status = stat_q;
      if (!stat_q[STAT_CONT_BIT]) wb_status[STAT_EMPTY_BIT] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= WK_IDLE;
         cur_q       <= '0;
         cnt_q       <= '0;
         ptr_q       <= '0;
         stat_q      <= '0;
         busy_seen_q <= 1'b0;
         irq_q       <= 1'b0;
         busy_q      <= 1'b0;
      end else begin
         irq_q  <= closing || busy_fire;
         busy_q <= busy_fire;
         if (!chan_en) begin
            state_q     <= WK_IDLE;
            cnt_q       <= '0;
            busy_seen_q <= 1'b0;
         end else begin
            case (state_q)
               WK_IDLE: begin
                  cur_q   <= base;
                  state_q <= WK_CHECK;
               end
               WK_CHECK: begin
                  if (st_empty) begin
                     stat_q      <= d_status;
                     ptr_q       <= d_ptr;
                     cnt_q       <= '0;
                     busy_seen_q <= 1'b0;
                     state_q     <= WK_ACTIVE;
                  end else if (busy_fire) begin
                     busy_seen_q <= 1'b1;
                  end
               end
               WK_ACTIVE: begin
                  if (closing) begin
                     cur_q   <= next_cur;
                     cnt_q   <= '0;
                     state_q <= WK_CHECK;
                  end else if (byte_in) begin
                     cnt_q <= cnt_q + LEN_W'(1);
                  end
               end
               default: state_q <= WK_IDLE;
            endcase
         end
      end
   end

   assign rd_idx    = cur_q[AW-1:1];
   assign wb_we     = closing;
   assign wb_idx    = cur_q[AW-1:1];
   assign wb_len    = 16'(len_final);
   assign buf_own   = (state_q == WK_ACTIVE);
   assign buf_we    = byte_in;
   assign buf_addr  = ptr_q + 32'(cnt_q);
   assign buf_wdata = rx_byte;
   assign irq       = irq_q;
   assign busy_err  = busy_q;

   AST_TAKE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == WK_CHECK && state_q == WK_ACTIVE) |-> $past(d_status[STAT_EMPTY_BIT]))
      else $error("descriptor taken while not empty"); // R3
   AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_err |=> !busy_err) else $error("busy pulse too long"); // R4
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == WK_CHECK && state_q == WK_CHECK && $past(chan_en)) |-> $stable(cur_q))
      else $error("pointer moved while stalled"); // R4
   AST_WE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> buf_own) else $error("byte write without ownership"); // R3
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WK_ACTIVE) |-> (cnt_q < maxlen)) else $error("count past maximum"); // R5
   AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != WK_IDLE) |-> (cur_q[2:0] == 3'b000)) else $error("descriptor misaligned"); // R8
endmodule

// File: rtl/bd_ring_walker.sv
module bd_ring_walker #(
   parameter int RAM_BYTES    = 128,
   parameter int LEN_W        = 16,
   parameter int DEF_MAXLEN   = 16,
   parameter bit ALIGN_REJECT = 1'b1,
   localparam int AW          = $clog2(RAM_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_en,
   input  logic          cfg_we,
   input  logic          cfg_sel,
   input  logic [15:0]   cfg_wdata,
   output logic [15:0]   cfg_rdata,
   input  logic          host_we,
   input  logic [AW-2:0] host_addr,
   input  logic [15:0]   host_wdata,
   output logic [15:0]   host_rdata,
   input  logic          rx_valid,
   input  logic [7:0]    rx_byte,
   input  logic          rx_eof,
   input  logic          close_cmd,
   output logic          buf_own,
   output logic          buf_we,
   output logic [31:0]   buf_addr,
   output logic [7:0]    buf_wdata,
   output logic          irq,
   output logic          busy_err
);
   if ((1 << AW) != RAM_BYTES) begin : g_bad_size
      $error("bd_ring_walker: RAM_BYTES must be a power of two");
   end

   logic [AW-1:0]    base;
   logic [LEN_W-1:0] maxlen;
   logic [AW-2:0]    rd_idx;
   logic [15:0]      d_status;
   logic [31:0]      d_ptr;
   logic             wb_we;
   logic [AW-2:0]    wb_idx;
   logic [15:0]      wb_status;
   logic [15:0]      wb_len;

   bdw_cfg_regs #(
      .AW(AW), .LEN_W(LEN_W), .DEF_MAXLEN(DEF_MAXLEN), .ALIGN_REJECT(ALIGN_REJECT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .base_q(base), .maxlen_q(maxlen)
   );

   bdw_desc_ram #(.AW(AW)) u_ram (
      .clk(clk), .rd_idx(rd_idx), .rd_status(d_status), .rd_ptr(d_ptr),
      .wb_we(wb_we), .wb_idx(wb_idx), .wb_status(wb_status), .wb_len(wb_len),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );

   bdw_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .base(base), .maxlen(maxlen),
      .d_status(d_status), .d_ptr(d_ptr), .rd_idx(rd_idx),
      .wb_we(wb_we), .wb_idx(wb_idx), .wb_status(wb_status), .wb_len(wb_len),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eof(rx_eof), .close_cmd(close_cmd),
      .buf_own(buf_own), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .irq(irq), .busy_err(busy_err)
   );

   AST_IRQ_COVERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_err |-> irq) else $error("busy without interrupt"); // R4
   AST_CLOSE_DROPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_we && chan_en) |=> !buf_own) else $error("ownership kept across close"); // R5
endmodule

// File: tb/bd_ring_walker_test.sv
module bd_ring_walker_test;
   localparam int CLK_PERIOD = 10;
   localparam int E_BIT = 16'h8000;
   localparam int W_BIT = 16'h2000;
   localparam int C_BIT = 16'h0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        host_we = 1'b0;
   logic [5:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_eof = 1'b0;
   logic        close_cmd = 1'b0;
   logic        buf_own, buf_we, irq, busy_err;
   logic [31:0] buf_addr;
   logic [7:0]  buf_wdata;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bd_ring_walker uut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eof(rx_eof), .close_cmd(close_cmd),
      .buf_own(buf_own), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .irq(irq), .busy_err(busy_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic cfg_wr(input logic sel, input logic [15:0] val);
      cfg_sel = sel; cfg_wdata = val; cfg_we = 1'b1;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input logic sel, output logic [15:0] val);
      cfg_sel = sel;
      #1 val = cfg_rdata;
   endtask

   task automatic host_wr(input int idx, input logic [15:0] val);
      host_addr = 6'(idx); host_wdata = val; host_we = 1'b1;
      tick();
      host_we = 1'b0;
   endtask

   task automatic host_rd(input int idx, output logic [15:0] val);
      host_addr = 6'(idx);
      #1 val = host_rdata;
   endtask

   task automatic desc_set(input int baddr, input logic [15:0] st, input logic [31:0] p);
      host_wr(baddr/2, st);
      host_wr(baddr/2 + 1, 16'h0);
      host_wr(baddr/2 + 2, p[31:16]);
      host_wr(baddr/2 + 3, p[15:0]);
   endtask

   task automatic send(input string tag, input logic [7:0] b, input logic eof,
                       input logic cmd, input logic [31:0] exp_addr);
      rx_valid = 1'b1; rx_byte = b; rx_eof = eof; close_cmd = cmd;
      #1;
      check({tag, " buf_we"}, 32'(buf_we), 32'd1);
      check({tag, " buf_addr"}, buf_addr, exp_addr);
      check({tag, " buf_wdata"}, 32'(buf_wdata), 32'(b));
      tick();
      rx_valid = 1'b0; rx_eof = 1'b0; close_cmd = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      tick(); tick();
      // R1 reset state
      #1;
      check("R1 buf_own", 32'(buf_own), 0);
      check("R1 buf_we", 32'(buf_we), 0);
      check("R1 irq", 32'(irq), 0);
      check("R1 busy_err", 32'(busy_err), 0);
      rst_n = 1'b1;
      tick();
      cfg_rd(1'b0, v); check("R1 base", 32'(v), 0);
      cfg_rd(1'b1, v); check("R1 maxlen", 32'(v), 16);

      // R2 configuration write rules
      cfg_wr(1'b0, 16'd12); cfg_rd(1'b0, v); check("R2 misaligned base rejected", 32'(v), 0);
      cfg_wr(1'b0, 16'd16); cfg_rd(1'b0, v); check("R2 aligned base", 32'(v), 16);
      cfg_wr(1'b1, 16'd0);  cfg_rd(1'b1, v); check("R2 zero maxlen rejected", 32'(v), 16);

      // R4 busy then R7 close command, R10 coincident close
      desc_set(16, 16'h0, 32'h0000_2000);
      desc_set(24, 16'(E_BIT | W_BIT), 32'h0000_3000);
      chan_en = 1'b1;
      tick(); tick(); #1;
      check("R4 busy pulse", 32'(busy_err), 1);
      check("R4 irq with busy", 32'(irq), 1);
      check("R4 no ownership", 32'(buf_own), 0);
      tick(); #1;
      check("R4 busy single", 32'(busy_err), 0);
      tick(); tick(); #1;
      check("R4 still stalled", 32'(buf_own), 0);
      check("R4 no repeat busy", 32'(busy_err), 0);
      cfg_wr(1'b0, 16'd40); cfg_rd(1'b0, v); check("R2 write ignored while enabled", 32'(v), 16);
      host_wr(8, 16'(E_BIT));
      tick(); #1;
      check("R4 taken after host sets empty", 32'(buf_own), 1);
      send("R3 byte0", 8'h11, 1'b0, 1'b0, 32'h0000_2000);
      send("R3 byte1", 8'h22, 1'b0, 1'b0, 32'h0000_2001);
      close_cmd = 1'b1; tick(); close_cmd = 1'b0; #1;
      check("R7 close irq", 32'(irq), 1);
      check("R7 own dropped", 32'(buf_own), 0);
      tick(); #1;
      check("R7 next desc owned", 32'(buf_own), 1);
      host_rd(9, v); check("R7 partial length", 32'(v), 2);
      host_rd(8, v); check("R5 empty cleared", 32'(v), 0);
      send("R7 data continues", 8'h33, 1'b0, 1'b0, 32'h0000_3000);
      send("R10 cmd with byte", 8'h44, 1'b0, 1'b1, 32'h0000_3001);
      #1 check("R10 close irq", 32'(irq), 1);
      tick(); #1;
      check("R8 wrap to base finds busy", 32'(busy_err), 1);
      check("R10 own low", 32'(buf_own), 0);
      host_rd(13, v); check("R10 single close length", 32'(v), 2);
      host_rd(12, v); check("R10 status wrap kept", 32'(v), 32'(W_BIT));

      // R9 continuous mode, R6 end of frame
      chan_en = 1'b0; tick();
      cfg_wr(1'b1, 16'd2);
      desc_set(16, 16'(E_BIT | W_BIT | C_BIT), 32'h0000_4000);
      chan_en = 1'b1;
      tick(); tick(); #1;
      check("R9 owned", 32'(buf_own), 1);
      cfg_wr(1'b1, 16'd5); cfg_rd(1'b1, v); check("R2 maxlen locked", 32'(v), 2);
      send("R9 byte0", 8'h55, 1'b0, 1'b0, 32'h0000_4000);
      send("R9 byte1", 8'h66, 1'b0, 1'b0, 32'h0000_4001);
      #1 check("R5 max close irq", 32'(irq), 1);
      tick(); #1;
      check("R9 reused at once", 32'(buf_own), 1);
      host_rd(8, v); check("R9 empty kept", 32'(v), 32'(E_BIT | W_BIT | C_BIT));
      host_rd(9, v); check("R9 length", 32'(v), 2);
      send("R6 eof byte", 8'h77, 1'b1, 1'b0, 32'h0000_4000);
      #1 check("R6 eof irq", 32'(irq), 1);
      host_rd(9, v); check("R6 eof length", 32'(v), 1);
      chan_en = 1'b0; tick();

      // R5 R8 sweep over ring size and maximum length
      for (int n = 1; n <= 3; n++) begin
         for (int m = 1; m <= 3; m++) begin
            int bse;
            bse = 8 * n;
            cfg_wr(1'b1, 16'(m));
            cfg_wr(1'b0, 16'(bse));
            for (int j = 0; j < n; j++)
               desc_set(bse + 8*j, 16'(E_BIT | ((j == n-1) ? W_BIT : 0)),
                        32'h0010_0000 + 32'(n*32'h1000 + m*32'h100 + j*16));
            chan_en = 1'b1;
            tick(); tick();
            for (int j = 0; j < n; j++) begin
               #1 check("R3 owned before bytes", 32'(buf_own), 1);
               for (int c = 0; c < m; c++)
                  send("R8 sweep byte", 8'(n*40 + m*10 + j*3 + c), 1'b0, 1'b0,
                       32'h0010_0000 + 32'(n*32'h1000 + m*32'h100 + j*16 + c));
               #1 check("R5 sweep close irq", 32'(irq), 1);
               check("R5 sweep own low", 32'(buf_own), 0);
               tick();
            end
            #1 check("R8 sweep wrap busy", 32'(busy_err), 1);
            for (int j = 0; j < n; j++) begin
               host_rd((bse + 8*j)/2 + 1, v); check("R5 sweep length", 32'(v), 32'(m));
               host_rd((bse + 8*j)/2, v);
               check("R5 sweep status", 32'(v), (j == n-1) ? 32'(W_BIT) : 32'd0);
            end
            chan_en = 1'b0; tick();
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule